// File: doc/BRIEF.md
# Third-Order Sigma-Delta Decimation Filter

This block turns a one-bit sigma-delta modulator stream into 16-bit filtered samples at 1/256 of the bit rate. It is a third-order cascaded integrator-comb filter in a single clock domain. The modulator bit is sampled on every clock edge, so the clock is the bit clock. A 1 counts as +1 and a 0 counts as 0.

Three integrators accumulate on every bit. A free-running counter raises a one-cycle word enable once every 256 bits. The three comb differentiators advance only on that enable. Each difference is formed combinationally against a registered delay element, so the comb path adds no pipeline stage. All internal arithmetic is 24-bit two's complement and wraps. The sample is the upper 16 bits of the last difference. It is registered together with a one-cycle valid strobe, after the filter has seen three full word periods.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is low, exactly one valid strobe is produced for every 256 clock cycles (input bits).
- R2: The word enable occurs exactly every 256 clocks, and the comb delay state changes only in cycles where the enable is high.
- R3: For a periodic input with k ones in every p bits, where p divides 256, the settled output word equals bits [23:8] of (2^24 * k / p) mod 2^24. For an 8-bit repeating pattern this is k * 0x2000. Here 1 = +1, 0 = 0, and pattern bit (n mod 8) drives the n-th clock.
- R4: An all-ones input wraps the 24-bit result to zero, so the settled output word is 0x0000.
- R5: After reset is released, the first valid strobe follows the 768th rising edge, and later strobes follow every 256th edge. Each strobe lasts exactly one cycle.
- R6: `out_word` changes only in a cycle where `out_valid` is high, and it holds its value in between.
- R7: While reset is high, `out_word` is 0 and `out_valid` is 0. After reset the R5 latency starts again from the release.
- R8: A stream with a single 1 in every 256 bits settles to an output word of 0x0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one modulator bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Sigma-delta modulator bit (1 = +1, 0 = 0) |
| out_word | output | 16 | Decimated sample, upper bits of the 24-bit comb result |
| out_valid | output | 1 | One-cycle strobe marking a new `out_word` |

## Verification
The hardest outputs to reach are exact, fully settled ones. This includes the full-density case, where the 24-bit gain of 2^24 wraps to zero. Each output depends on about 770 preceding bits, and the modulator phase relative to the word boundary is arbitrary. The stimulus therefore uses repeating patterns whose period divides 256. For those, every box-filter stage sees a constant window sum, so the settled result is known exactly whatever the alignment. Each pattern runs for six word periods, and the bench checks the last strobed word. A reset in the middle of a run checks that the 768-edge latency restarts.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
   localparam int unsigned DEF_DECIM = 256;
   localparam int unsigned DEF_ACC_W = 24;
   localparam int unsigned DEF_OUT_W = 16;
   localparam int unsigned DEF_ORDER = 3;
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int unsigned ORDER = sinc3_pkg::DEF_ORDER,
   parameter int unsigned ACC_W = sinc3_pkg::DEF_ACC_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_bit,
   output logic [ACC_W-1:0] acc_last
);
   logic [ORDER-1:0][ACC_W-1:0] stage_q;

   for (genvar s = 0; s < ORDER; s++) begin : g_stage
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] addend;
      if (s == 0) begin : g_first
         assign addend = {{(ACC_W-1){1'b0}}, in_bit};
      end else begin : g_next
         assign addend = stage_q[s-1];
      end
      always_ff @(posedge clk) begin
         if (rst) acc_q <= '0;
         else     acc_q <= acc_q + addend;
      end
      assign stage_q[s] = acc_q;
   end

   assign acc_last = stage_q[ORDER-1];
endmodule

// File: rtl/sinc3_rate.sv
module sinc3_rate #(
   parameter int unsigned DECIM = sinc3_pkg::DEF_DECIM,
   parameter int unsigned ORDER = sinc3_pkg::DEF_ORDER
) (
   input  logic clk,
   input  logic rst,
   output logic word_en,
   output logic filled
);
   localparam int unsigned CNT_W  = $clog2(DECIM);
   localparam int unsigned FILL_W = $clog2(ORDER + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [FILL_W-1:0] fill_q;

   assign word_en = (cnt_q == CNT_W'(DECIM - 1));
   assign filled  = (fill_q == FILL_W'(ORDER - 1));

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)                  fill_q <= '0;
      else if (word_en && !filled) fill_q <= fill_q + FILL_W'(1);
   end
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int unsigned ORDER = sinc3_pkg::DEF_ORDER,
   parameter int unsigned ACC_W = sinc3_pkg::DEF_ACC_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [ACC_W-1:0] in_val,
   output logic [ACC_W-1:0] out_val,
   output logic [ACC_W-1:0] tail_dly
);
   logic [ORDER:0][ACC_W-1:0]   link;
   logic [ORDER-1:0][ACC_W-1:0] dly_all;

   assign link[0] = in_val;

   for (genvar s = 0; s < ORDER; s++) begin : g_stage
      logic [ACC_W-1:0] dly_q;
      always_ff @(posedge clk) begin
         if (rst)     dly_q <= '0;
         else if (en) dly_q <= link[s];
      end
      assign link[s+1]  = link[s] - dly_q;
      assign dly_all[s] = dly_q;
   end

   assign out_val  = link[ORDER];
   assign tail_dly = dly_all[ORDER-1];
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
   parameter int unsigned DECIM = sinc3_pkg::DEF_DECIM,
   parameter int unsigned ACC_W = sinc3_pkg::DEF_ACC_W,
   parameter int unsigned OUT_W = sinc3_pkg::DEF_OUT_W,
   parameter int unsigned ORDER = sinc3_pkg::DEF_ORDER
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mod_bit,
   output logic [OUT_W-1:0] out_word,
   output logic             out_valid
);
   if (DECIM < 2 || (DECIM & (DECIM - 1)) != 0) begin : g_bad_decim
      $error("DECIM must be a power of two of at least 2");
   end
   if (OUT_W > ACC_W || OUT_W == 0) begin : g_bad_out
      $error("OUT_W must lie between 1 and ACC_W");
   end
   if (ORDER < 1) begin : g_bad_order
      $error("ORDER must be at least 1");
   end

   logic [ACC_W-1:0] integ_out;
   logic [ACC_W-1:0] comb_out;
   logic [ACC_W-1:0] comb_tail;
   logic             word_en;
   logic             filled;

   sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
      .clk(clk), .rst(rst), .in_bit(mod_bit), .acc_last(integ_out)
   );

   sinc3_rate #(.DECIM(DECIM), .ORDER(ORDER)) u_rate (
      .clk(clk), .rst(rst), .word_en(word_en), .filled(filled)
   );

   sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
      .clk(clk), .rst(rst), .en(word_en), .in_val(integ_out),
      .out_val(comb_out), .tail_dly(comb_tail)
   );

   logic [OUT_W-1:0] word_next;
   assign word_next = comb_out[ACC_W-1 -: OUT_W];

   if (ACC_W > OUT_W) begin : g_trunc
      logic unused_low;
      assign unused_low = ^comb_out[ACC_W-OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_word  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= word_en && filled;
         if (word_en && filled) out_word <= word_next;
      end
   end
endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk #(
   parameter int unsigned DECIM = 256,
   parameter int unsigned ACC_W = 24,
   parameter int unsigned OUT_W = 16,
   parameter int unsigned ORDER = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             word_en,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_word,
   input logic [ACC_W-1:0] comb_tail
);
   int unsigned gap_q;
   int unsigned seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= 0;
         seen_q <= 0;
      end else begin
         gap_q <= word_en ? 0 : gap_q + 1;
         if (word_en && seen_q < ORDER) seen_q <= seen_q + 1;
      end
   end

   p_word_period_r2: assert property (@(posedge clk) disable iff (rst)
      word_en |-> gap_q == DECIM - 1);

   p_comb_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !word_en |=> $stable(comb_tail));

   p_first_valid_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> seen_q >= ORDER);

   p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_word));

   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (out_word == '0 && !out_valid));
endmodule

bind sinc3_decimator sinc3_decimator_chk #(
   .DECIM(DECIM), .ACC_W(ACC_W), .OUT_W(OUT_W), .ORDER(ORDER)
) u_chk (
   .clk(clk), .rst(rst), .word_en(word_en), .out_valid(out_valid),
   .out_word(out_word), .comb_tail(comb_tail)
);

// File: tb/sinc3_decimator_test.sv
`timescale 1ns/1ps
module sinc3_decimator_test;
   localparam int DECIM = 256;
   localparam int NVEC  = 7;

   typedef struct packed {
      logic [7:0]  pat;
      logic [15:0] exp_word;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{8'h00, 16'h0000},
      '{8'h01, 16'h2000},
      '{8'h11, 16'h4000},
      '{8'h55, 16'h8000},
      '{8'h0F, 16'h8000},
      '{8'h3F, 16'hC000},
      '{8'h7F, 16'hE000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mod_bit = 1'b0;
   logic [15:0] out_word;
   logic        out_valid;

   int checks = 0;
   int fails = 0;
   int edge_n = 0;
   int bit_idx = 0;
   int vcount = 0;
   int timing_err = 0;
   int hold_err = 0;
   logic [15:0] last_w = '0;
   logic [7:0]  pat = 8'h00;
   bit          sparse = 1'b0;

   sinc3_decimator uut (
      .clk(clk), .rst(rst), .mod_bit(mod_bit),
      .out_word(out_word), .out_valid(out_valid)
   );

   always #10 clk = ~clk;

   task automatic report();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      report();
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!rst) begin
            if (out_valid != ((edge_n >= 3*DECIM-1) && (edge_n % DECIM == DECIM-1)))
               timing_err++;
            if (out_valid) begin
               vcount++;
               last_w = out_word;
            end else if (out_word != last_w) begin
               hold_err++;
            end
            edge_n++;
         end
         mod_bit = sparse ? (bit_idx % DECIM == 0) : pat[bit_idx % 8];
         bit_idx++;
      end
   endtask

   task automatic release_rst();
      rst = 1'b0;
      edge_n = 0;
      vcount = 0;
      last_w = '0;
   endtask

   initial begin
      step(4);
      // R7: reset state
      check("R7 reset out_word", out_word, 0);
      check("R7 reset out_valid", out_valid, 0);
      release_rst();

      // R3: table of periodic patterns and settled words
      for (int v = 0; v < NVEC; v++) begin
         pat = VECS[v].pat;
         step(6*DECIM);
         if (v == 0) check("R5 first valid count after 1536 edges", vcount, 4);
         check($sformatf("R3 pattern %02h", VECS[v].pat), last_w, VECS[v].exp_word);
      end

      // R4: full density wraps to zero
      pat = 8'hFF;
      step(6*DECIM);
      check("R4 all-ones wrap", last_w, 16'h0000);

      // R8: one pulse per word
      sparse = 1'b1;
      step(6*DECIM);
      check("R8 sparse density", last_w, 16'h0100);
      sparse = 1'b0;

      // R1: strobe count over a known stretch
      pat = 8'h55;
      vcount = 0;
      step(4*DECIM);
      check("R1 strobes per 1024 bits", vcount, 4);
      check("R3 pattern 55 after 1-per-word", last_w, 16'h8000);

      // R7: mid-run reset clears and restarts latency
      rst = 1'b1;
      step(2);
      check("R7 mid-run reset out_word", out_word, 0);
      check("R7 mid-run reset out_valid", out_valid, 0);
      release_rst();
      step(3*DECIM - 1);
      check("R7 no strobe before 768 edges after reset", vcount, 0);
      step(1);
      check("R5 strobe right after edge 767", vcount, 1);
      step(2*DECIM);
      check("R1 strobes after restart", vcount, 3);

      check("R5 strobe timing mismatches", timing_err, 0);
      check("R6 word changed without strobe", hold_err, 0);
      report();
   end
endmodule